// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a 32-bit digital input port and raises one level interrupt when selected inputs change. All 32 inputs pass through a synchronizer, and software can read their settled value. The low 16 channels can also take part in interrupt generation. Each of these channels is selected through two 32-bit masks: a rise/high mask and a fall/low mask.

The controller works in one of two combination modes. In any-edge mode, a rising edge on a channel in the rise/high mask, or a falling edge on a channel in the fall/low mask, is captured into a sticky status register. In all-level mode, the block fires once when every channel in the rise/high mask reads 1 and every channel in the fall/low mask reads 0. It then holds off until some selected channel changes level. A read of the status register returns the captured channels and clears them. The interrupt line stays high while the status is nonzero and the global enable is set.

Access is through a simple single-cycle register bus. Read data is combinational in the request cycle, and a write takes effect at the clock edge that ends the request.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero and irq_o is low.
- R2: A value held on din_i for at least three clocks reads back unchanged, all 32 bits, at byte offset 0x00.
- R3: The rise/high mask (0x04) and the fall/low mask (0x08) are 32-bit read/write registers. In the control register (0x10), bit 1 selects the mode (0 = any-edge, 1 = all-level) and bit 2 is the global enable; its other bits read as 0.
- R4: In any-edge mode with the enable set, a rising edge on a channel in the rise/high mask sets that channel's status bit and raises irq_o, no later than the third clock edge after din_i changes.
- R5: A read of offset 0x0C returns the captured channels in bits 15:0, with bits 31:16 zero, and clears the status. irq_o then falls.
- R6: In any-edge mode, a falling edge on a channel in the fall/low mask is captured. An edge of the other polarity on a channel that is only in the fall/low mask is not captured.
- R7: Channels 16 to 31 never set status, even when their mask bits are set.
- R8: In all-level mode with the enable set, once every rise/high-mask channel reads 1 and every fall/low-mask channel reads 0 (at least one channel selected), status becomes the set of selected channels and irq_o rises.
- R9: After an all-level firing, no new firing occurs until a selected channel changes level. A change on an unselected channel does not rearm the block.
- R10: While the enable is clear, irq_o is low and no new event is captured. Setting the enable again raises irq_o for status already pending, and the masks keep their values.
- R11: When a status read coincides with the clock edge that captures a new event, the read returns the old status and the new event stays pending.
- R12: With both masks zero and the enable set, no input activity sets any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| din_i | input | 32 | Asynchronous digital inputs |
| irq_o | output | 1 | Level interrupt |

## Verification
The bound checker checks the following on every clock: no status bit appears while the enable is clear; a status read with the enable clear leaves the status empty; any-edge mode captures every masked rising edge on the next edge; all-level mode adds nothing to the status while it is blocked; and the interrupt stays high until it is read or disabled. Only the bench scenarios can show the rest. These are the synchronizer latency seen at the raw register, the mask readback, the AND-condition that requires all channels, the rearm that only a selected channel can trigger, the read that collides with a new event, and the inertness of channels 16 to 31.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned OFS_RAW  = 32'h00;
  localparam int unsigned OFS_RISE = 32'h04;
  localparam int unsigned OFS_FALL = 32'h08;
  localparam int unsigned OFS_STAT = 32'h0C;
  localparam int unsigned OFS_CTRL = 32'h10;

  localparam int unsigned CTRL_MODE_BIT = 1;
  localparam int unsigned CTRL_EN_BIT   = 2;

  typedef enum logic {
    COMB_ANY = 1'b0,
    COMB_ALL = 1'b1
  } comb_mode_e;

  typedef struct packed {
    logic       en;
    comb_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2,
  parameter int unsigned EDGE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  async_i,
  output logic [WIDTH-1:0]  sync_o,
  output logic [EDGE_W-1:0] prev_o
);
  logic [WIDTH-1:0]  stg_q [STAGES];
  logic [EDGE_W-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  // one extra stage on the interrupt-capable slice for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1][EDGE_W-1:0];
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int unsigned CH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [CH-1:0] cur_i,
  input  logic [CH-1:0] prev_i,
  input  logic [CH-1:0] mask_hi_i,
  input  logic [CH-1:0] mask_lo_i,
  output logic [CH-1:0] hit_o,
  output logic          blocked_o
);
  logic [CH-1:0] rise, fall, sel, edge_hit;
  logic          all_ok, moved, and_fire, blocked_q, blocked_d;

  assign rise     = cur_i & ~prev_i;
  assign fall     = ~cur_i & prev_i;
  assign sel      = mask_hi_i | mask_lo_i;
  assign edge_hit = (rise & mask_hi_i) | (fall & mask_lo_i);
  assign all_ok   = (|sel) && ((cur_i & mask_hi_i) == mask_hi_i)
                           && ((~cur_i & mask_lo_i) == mask_lo_i);
  assign moved    = |((rise | fall) & sel);
  assign and_fire = ctrl_i.en && (ctrl_i.mode == COMB_ALL) && all_ok && !blocked_q;

  always_comb begin
    hit_o = '0;
    if (ctrl_i.en) begin
      if (ctrl_i.mode == COMB_ALL) hit_o = and_fire ? sel : '0;
      else                         hit_o = edge_hit;
    end
  end

  always_comb begin
    blocked_d = blocked_q;
    if (ctrl_i.mode != COMB_ALL) blocked_d = 1'b0;
    else if (and_fire)           blocked_d = 1'b1;
    else if (moved)              blocked_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blocked_q <= 1'b0;
    else         blocked_q <= blocked_d;
  end

  assign blocked_o = blocked_q;
endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CH     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] raw_i,
  input  logic [CH-1:0]     hit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CH-1:0]     mask_hi_o,
  output logic [CH-1:0]     mask_lo_o,
  output ctrl_t             ctrl_o,
  output logic [CH-1:0]     status_o,
  output logic              rd_status_o
);
  logic [DATA_W-1:0] mask_hi_q, mask_lo_q;
  ctrl_t             ctrl_q;
  logic [CH-1:0]     status_q;
  logic              wr, rd;

  assign wr          = req_i && we_i;
  assign rd          = req_i && !we_i;
  assign rd_status_o = rd && (addr_i == ADDR_W'(OFS_STAT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      ctrl_q    <= '0;
    end else if (wr) begin
      if (addr_i == ADDR_W'(OFS_RISE)) mask_hi_q <= wdata_i;
      if (addr_i == ADDR_W'(OFS_FALL)) mask_lo_q <= wdata_i;
      if (addr_i == ADDR_W'(OFS_CTRL)) begin
        ctrl_q.en   <= wdata_i[CTRL_EN_BIT];
        ctrl_q.mode <= comb_mode_e'(wdata_i[CTRL_MODE_BIT]);
      end
    end
  end

  // new hits win over a coincident clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (rd_status_o ? '0 : status_q) | hit_i;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (addr_i == ADDR_W'(OFS_RAW))  rdata_o = raw_i;
      if (addr_i == ADDR_W'(OFS_RISE)) rdata_o = mask_hi_q;
      if (addr_i == ADDR_W'(OFS_FALL)) rdata_o = mask_lo_q;
      if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = DATA_W'(status_q);
      if (addr_i == ADDR_W'(OFS_CTRL)) begin
        rdata_o[CTRL_EN_BIT]   = ctrl_q.en;
        rdata_o[CTRL_MODE_BIT] = ctrl_q.mode;
      end
    end
  end

  assign mask_hi_o = mask_hi_q[CH-1:0];
  assign mask_lo_o = mask_lo_q[CH-1:0];
  assign ctrl_o    = ctrl_q;
  assign status_o  = status_q;
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned IRQ_CH      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] din_i,
  output logic              irq_o
);
  logic [DATA_W-1:0] cur;
  logic [IRQ_CH-1:0] prev, mask_hi, mask_lo, hit, status;
  ctrl_t             ctrl;
  logic              rd_status, blocked;

  cos_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .EDGE_W(IRQ_CH)) u_sync (
    .clk_i, .rst_ni, .async_i(din_i), .sync_o(cur), .prev_o(prev)
  );

  cos_detect #(.CH(IRQ_CH)) u_detect (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .cur_i(cur[IRQ_CH-1:0]), .prev_i(prev),
    .mask_hi_i(mask_hi), .mask_lo_i(mask_lo), .hit_o(hit), .blocked_o(blocked)
  );

  cos_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH(IRQ_CH)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .raw_i(cur), .hit_i(hit),
    .rdata_o, .mask_hi_o(mask_hi), .mask_lo_o(mask_lo), .ctrl_o(ctrl),
    .status_o(status), .rd_status_o(rd_status)
  );

  assign irq_o = ctrl.en && (|status);
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int unsigned CH = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          mode_all_i,
  input logic          rd_status_i,
  input logic          blocked_i,
  input logic          irq_i,
  input logic [CH-1:0] cur_i,
  input logic [CH-1:0] prev_i,
  input logic [CH-1:0] mask_hi_i,
  input logic [CH-1:0] status_i
);
  assert_no_capture_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ((status_i & ~$past(status_i)) == '0));

  assert_irq_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !rd_status_i) |=> (irq_i || !en_i));

  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i && !en_i) |=> (status_i == '0));

  assert_rise_captured_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !mode_all_i && |(cur_i & ~prev_i & mask_hi_i))
      |=> (($past(cur_i & ~prev_i & mask_hi_i) & ~status_i) == '0));

  assert_blocked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_all_i && blocked_i) |=> ((status_i & ~$past(status_i)) == '0));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.CH(IRQ_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ctrl.en), .mode_all_i(logic'(ctrl.mode)),
  .rd_status_i(rd_status), .blocked_i(blocked), .irq_i(irq_o),
  .cur_i(cur[IRQ_CH-1:0]), .prev_i(prev), .mask_hi_i(mask_hi), .status_i(status)
);

// File: tb/cos_irq_ctrl_test.sv
`timescale 1ns/1ps
module cos_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, din = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cos_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .din_i(din), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // driver: issues the read and pushes the expected word to the scoreboard
  task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic set_din(input logic [31:0] v, input int n);
    din = v;
    wait_cyc(n);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #1 check({31'd0, irq}, {31'd0, exp}, tag);
  endtask

  // monitor: pops and compares as reads complete
  always @(negedge clk) begin
    #2;
    if (req && !we) begin
      if (exp_q.size() == 0) check(rdata, 32'hxxxx_xxxx, "scoreboard empty");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic finish_run();
    #5;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    bus_read(5'h00, 32'h0, "R1 raw");
    bus_read(5'h04, 32'h0, "R1 rise mask");
    bus_read(5'h08, 32'h0, "R1 fall mask");
    bus_read(5'h0C, 32'h0, "R1 status");
    bus_read(5'h10, 32'h0, "R1 ctrl");
    // R2 raw input
    set_din(32'hA5A5_0F0E, 3);
    bus_read(5'h00, 32'hA5A5_0F0E, "R2 raw");
    set_din(32'h0, 3);
    bus_read(5'h00, 32'h0, "R2 raw zero");
    // R3 masks and control
    bus_write(5'h04, 32'h0001_0001);
    bus_write(5'h08, 32'h0000_0002);
    bus_write(5'h10, 32'hFFFF_FFFB);
    bus_read(5'h10, 32'h2, "R3 ctrl mode only");
    bus_write(5'h10, 32'h4);
    bus_read(5'h04, 32'h0001_0001, "R3 rise mask");
    bus_read(5'h08, 32'h0000_0002, "R3 fall mask");
    bus_read(5'h10, 32'h4, "R3 ctrl");
    // R4 rising edge
    set_din(32'h1, 3);
    chk_irq(1'b1, "R4 irq on rise");
    // R5 read and clear
    bus_read(5'h0C, 32'h1, "R5 status value");
    chk_irq(1'b0, "R5 irq cleared");
    bus_read(5'h0C, 32'h0, "R5 status empty");
    // R6 falling edge
    set_din(32'h3, 3);
    chk_irq(1'b0, "R6 rise on fall-only channel");
    set_din(32'h1, 3);
    chk_irq(1'b1, "R6 irq on fall");
    bus_read(5'h0C, 32'h2, "R6 status");
    // R7 upper channels inert
    set_din(32'h0001_0001, 4);
    chk_irq(1'b0, "R7 irq");
    bus_read(5'h0C, 32'h0, "R7 status");
    set_din(32'h1, 4);
    // R11 coincident read
    set_din(32'h3, 3);
    set_din(32'h1, 3);
    set_din(32'h0, 3);
    din = 32'h1;
    wait_cyc(2);
    bus_read(5'h0C, 32'h2, "R11 old status");
    chk_irq(1'b1, "R11 new event pending");
    bus_read(5'h0C, 32'h1, "R11 new status");
    chk_irq(1'b0, "R11 irq after clear");
    // R10 enable gating
    set_din(32'h0, 3);
    set_din(32'h1, 3);
    chk_irq(1'b1, "R10 pending before disable");
    bus_write(5'h10, 32'h0);
    chk_irq(1'b0, "R10 irq suppressed");
    set_din(32'h3, 3);
    set_din(32'h1, 3);
    bus_write(5'h10, 32'h4);
    chk_irq(1'b1, "R10 irq restored");
    bus_read(5'h04, 32'h0001_0001, "R10 mask kept");
    bus_read(5'h0C, 32'h1, "R10 no capture while disabled");
    // R12 zero masks
    bus_write(5'h04, 32'h0);
    bus_write(5'h08, 32'h0);
    set_din(32'h0, 3);
    set_din(32'hFFFF_FFFF, 3);
    set_din(32'h1, 3);
    chk_irq(1'b0, "R12 irq");
    bus_read(5'h0C, 32'h0, "R12 status");
    // R8 all-level mode: bits 0,1 high, bit 2 low
    bus_write(5'h10, 32'h0);
    bus_write(5'h04, 32'h3);
    bus_write(5'h08, 32'h4);
    set_din(32'h1, 3);
    bus_write(5'h10, 32'h6);
    wait_cyc(3);
    chk_irq(1'b0, "R8 partial match");
    set_din(32'h3, 4);
    chk_irq(1'b1, "R8 full match");
    bus_read(5'h0C, 32'h7, "R8 status");
    // R9 blocking and rearm
    wait_cyc(4);
    chk_irq(1'b0, "R9 no refire while held");
    set_din(32'h23, 5);
    set_din(32'h03, 5);
    chk_irq(1'b0, "R9 unselected change no rearm");
    bus_read(5'h0C, 32'h0, "R9 status stays empty");
    set_din(32'h7, 5);
    chk_irq(1'b0, "R9 selected change, mismatch");
    set_din(32'h3, 5);
    chk_irq(1'b1, "R9 refire after rearm");
    bus_read(5'h0C, 32'h7, "R9 status");
    wait_cyc(2);
    finish_run();
  end
endmodule